// File: doc/BRIEF.md
# Programmed-I/O Sector Data Port

This block is the host-facing data port of a serial storage controller. It sits between a register-style host bus and two speed-matching word FIFOs. A host read of the port takes the oldest word out of a receive FIFO that the link side fills. A host write appends a word to a transmit FIFO that the link side empties. If the FIFO cannot serve an access, the port does not stall the bus. One cycle later it answers with a retry pulse, and the host must repeat the access.

On top of the data path, the block paces a programmed-I/O command in whole sectors. A command gives a direction, a sector count and a pacing mode. The block counts the words the host moves in that direction. At each sector boundary it steps a remaining-sector counter and a per-block counter. It raises a level interrupt at the start of every block of sectors, and it sets a completion flag when the count runs out. In single-sector pacing a block is one sector. In multiple-sector pacing a block is the programmed sectors-per-block value, except that the last block holds only the sectors that remain. A mode strap is captured during reset, and the captured value selects the programming interface that the surrounding logic presents.

Top module: `pio_sector_port`

## Requirements
- R1: A host read (`hostRd`) while the receive FIFO holds data removes its oldest word. One cycle later `hostAck` pulses, and `hostRData` carries that word. Words come out in the order the link pushed them.
- R2: A host write (`hostWr`) while the transmit FIFO has room stores `hostWData` and pulses `hostAck` one cycle later. A link pop (`linkTxPop` while `linkTxValid`) removes the oldest word, which appears on `linkTxData` in the following cycle.
- R3: A host read that finds the receive FIFO empty, or a host write that finds the transmit FIFO full, pulses `hostRetry` instead of `hostAck` one cycle later. It leaves the FIFO contents unchanged: a refused write stores nothing and drops none of the words already queued.
- R4: Each FIFO holds `FIFO_DEPTH` words (16 by default). `linkRxReady` is low while the receive FIFO is full, and a link push made while it is full is ignored.
- R5: `cmdStart` while idle with a non-zero `cmdCount` sets `xferBusy` and `irq` in the next cycle. A count of zero, or a start while busy, is ignored.
- R6: In single-sector pacing (`cmdMulti`=0), `irq` is set again after each completed sector of `SECTOR_WORDS` words, as long as sectors remain. It is never set in the middle of a sector.
- R7: In multiple-sector pacing (`cmdMulti`=1), `irq` is set after every block of B completed sectors, where B is the `cfgBlkData` value written through `cfgBlkWe` (0 is treated as 1). A shorter final block gets exactly one interrupt, at its start.
- R8: A `statusRd` pulse clears `irq` in the next cycle, unless a new interrupt is set in that same cycle.
- R9: When the last word of the last sector moves, `xferBusy` falls and `xferDone` rises in the next cycle. `xferDone` stays set until the next accepted `cmdStart`.
- R10: `dpaMode` takes the value of `modeStrap` at the clock edges while `rstN` is low, and it holds that value unchanged after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared host and link clock |
| rstN | input | 1 | Active-low reset; modeStrap is captured while low |
| modeStrap | input | 1 | Interface mode strap |
| dpaMode | output | 1 | Captured mode: 1 = direct port access, 0 = compatible IDE |
| hostRd | input | 1 | Host read of the data port |
| hostWr | input | 1 | Host write of the data port (ignored when hostRd is high) |
| hostWData | input | DATA_W | Host write word |
| hostRData | output | DATA_W | Word returned by the last accepted read |
| hostAck | output | 1 | Access accepted (one cycle after the request) |
| hostRetry | output | 1 | Access refused, host must retry (one cycle after the request) |
| statusRd | input | 1 | Status read strobe, clears irq |
| cmdStart | input | 1 | Start a sector transfer |
| cmdIsWrite | input | 1 | Direction: 1 = host writes, 0 = host reads |
| cmdMulti | input | 1 | 1 = multiple-sector pacing |
| cmdCount | input | CNT_W | Sector count |
| cfgBlkWe | input | 1 | Load the sectors-per-block value |
| cfgBlkData | input | CNT_W | Sectors per block |
| irq | output | 1 | Level interrupt, block ready |
| xferBusy | output | 1 | Transfer in progress |
| xferDone | output | 1 | Sector count exhausted |
| linkRxValid | input | 1 | Link pushes a received word |
| linkRxData | input | DATA_W | Received word |
| linkRxReady | output | 1 | Receive FIFO not full |
| linkTxPop | input | 1 | Link takes a word to send |
| linkTxData | output | DATA_W | Word taken by the last pop |
| linkTxValid | output | 1 | Transmit FIFO not empty |

## Verification
Assertions check on every cycle that the acknowledge and retry pulses never coincide and that no FIFO's fill level exceeds its depth. They also check that a full FIFO refuses a push, that completion never coexists with busy, that an interrupt only rises during a transfer, that the current block never exceeds the remaining sectors, and that the captured strap stays stable. Only the bench scenarios can show that words come out in the right order, that refused accesses leave the queues intact, and that interrupts arrive at exactly the right sector boundaries. These scenarios cover single-sector pacing and multiple-sector pacing with a short final block, in both directions and under random counts and block sizes.

// File: rtl/pio_port_pkg.sv
package pio_port_pkg;

  // Strobes from control to datapath for one host access
  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic ackSet;
    logic retrySet;
  } hostStrobe_t;

  // FIFO state reported by the datapath to control
  typedef struct packed {
    logic rxEmpty;
    logic txFull;
  } fifoFlags_t;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } xferDir_t;

endpackage

// File: rtl/pio_sync_fifo.sv
module pio_sync_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      fill;
  logic             doPush, doPop;

  assign empty  = (fill == '0);
  assign full   = (fill == (AW+1)'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      popData <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (doPop) begin
        rdPtr   <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
        popData <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    fill <= (AW+1)'(DEPTH));

  assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);

endmodule

// File: rtl/pio_port_datapath.sv
module pio_port_datapath
  import pio_port_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  output fifoFlags_t        flags,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hostAck,
  output logic              hostRetry,
  input  logic              linkRxValid,
  input  logic [DATA_W-1:0] linkRxData,
  output logic              linkRxReady,
  input  logic              linkTxPop,
  output logic [DATA_W-1:0] linkTxData,
  output logic              linkTxValid
);
  logic rxFull, rxEmpty, txFull, txEmpty;

  pio_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (linkRxValid),
    .pushData (linkRxData),
    .pop      (strobe.rxPop),
    .popData  (hostRData),
    .empty    (rxEmpty),
    .full     (rxFull)
  );

  pio_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.txPush),
    .pushData (hostWData),
    .pop      (linkTxPop),
    .popData  (linkTxData),
    .empty    (txEmpty),
    .full     (txFull)
  );

  assign flags.rxEmpty = rxEmpty;
  assign flags.txFull  = txFull;
  assign linkRxReady   = !rxFull;
  assign linkTxValid   = !txEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostAck   <= 1'b0;
      hostRetry <= 1'b0;
    end else begin
      hostAck   <= strobe.ackSet;
      hostRetry <= strobe.retrySet;
    end
  end

  assert_ack_retry_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(hostAck && hostRetry));

  assert_retry_keeps_rx_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retrySet && !strobe.txPush && !linkRxValid && rxEmpty) |=> rxEmpty);

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_port_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int SECTOR_WORDS = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostRd,
  input  logic             hostWr,
  input  fifoFlags_t       flags,
  output hostStrobe_t      strobe,
  input  logic             statusRd,
  input  logic             cmdStart,
  input  logic             cmdIsWrite,
  input  logic             cmdMulti,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             cfgBlkWe,
  input  logic [CNT_W-1:0] cfgBlkData,
  output logic             irq,
  output logic             xferBusy,
  output logic             xferDone
);
  localparam int WCW = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
  localparam logic [WCW-1:0] LAST_WORD = WCW'(SECTOR_WORDS - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfgBlk, blkSizeQ, remain, blockLeft;
  logic [CNT_W-1:0] startBlkSize, firstBlock, nextBlock;
  logic [WCW-1:0]   wordCnt;
  xferDir_t         dirQ;
  logic             beat, startOk, sectorEnd;

  function automatic logic [CNT_W-1:0] minCnt(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Host access arbitration: read wins over write
  always_comb begin
    strobe          = '0;
    strobe.rxPop    = hostRd && !flags.rxEmpty;
    strobe.txPush   = !hostRd && hostWr && !flags.txFull;
    strobe.ackSet   = strobe.rxPop || strobe.txPush;
    strobe.retrySet = (hostRd && flags.rxEmpty) || (!hostRd && hostWr && flags.txFull);
  end

  assign startOk      = cmdStart && !xferBusy && (cmdCount != '0);
  assign startBlkSize = cmdMulti ? cfgBlk : ONE;
  assign firstBlock   = minCnt(startBlkSize, cmdCount);
  assign nextBlock    = minCnt(blkSizeQ, remain - ONE);
  assign beat         = xferBusy && ((dirQ == DIR_READ) ? strobe.rxPop : strobe.txPush);
  assign sectorEnd    = beat && (wordCnt == LAST_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBlk <= ONE;
    end else if (cfgBlkWe) begin
      cfgBlk <= (cfgBlkData == '0) ? ONE : cfgBlkData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferBusy  <= 1'b0;
      xferDone  <= 1'b0;
      irq       <= 1'b0;
      dirQ      <= DIR_READ;
      blkSizeQ  <= ONE;
      remain    <= '0;
      blockLeft <= '0;
      wordCnt   <= '0;
    end else if (startOk) begin
      xferBusy  <= 1'b1;
      xferDone  <= 1'b0;
      irq       <= 1'b1;
      dirQ      <= cmdIsWrite ? DIR_WRITE : DIR_READ;
      blkSizeQ  <= startBlkSize;
      remain    <= cmdCount;
      blockLeft <= firstBlock;
      wordCnt   <= '0;
    end else begin
      if (statusRd) irq <= 1'b0;
      if (sectorEnd) begin
        wordCnt <= '0;
        remain  <= remain - ONE;
        if (remain == ONE) begin
          xferBusy  <= 1'b0;
          xferDone  <= 1'b1;
          blockLeft <= '0;
        end else if (blockLeft == ONE) begin
          blockLeft <= nextBlock;
          irq       <= 1'b1;
        end else begin
          blockLeft <= blockLeft - ONE;
        end
      end else if (beat) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !xferBusy);

  assert_irq_in_xfer_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> xferBusy);

  assert_block_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> (blockLeft != '0 && blockLeft <= remain));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !cmdStart && !sectorEnd) |=> !irq);

endmodule

// File: rtl/pio_sector_port.sv
module pio_sector_port
  import pio_port_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int FIFO_DEPTH   = 16,
  parameter int SECTOR_WORDS = 256,
  parameter int CNT_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrap,
  output logic              dpaMode,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hostAck,
  output logic              hostRetry,
  input  logic              statusRd,
  input  logic              cmdStart,
  input  logic              cmdIsWrite,
  input  logic              cmdMulti,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              cfgBlkWe,
  input  logic [CNT_W-1:0]  cfgBlkData,
  output logic              irq,
  output logic              xferBusy,
  output logic              xferDone,
  input  logic              linkRxValid,
  input  logic [DATA_W-1:0] linkRxData,
  output logic              linkRxReady,
  input  logic              linkTxPop,
  output logic [DATA_W-1:0] linkTxData,
  output logic              linkTxValid
);
  hostStrobe_t strobe;
  fifoFlags_t  flags;

  // Strap capture: follows the pin while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rstN) dpaMode <= modeStrap;
  end

  pio_port_ctrl #(.CNT_W(CNT_W), .SECTOR_WORDS(SECTOR_WORDS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .flags      (flags),
    .strobe     (strobe),
    .statusRd   (statusRd),
    .cmdStart   (cmdStart),
    .cmdIsWrite (cmdIsWrite),
    .cmdMulti   (cmdMulti),
    .cmdCount   (cmdCount),
    .cfgBlkWe   (cfgBlkWe),
    .cfgBlkData (cfgBlkData),
    .irq        (irq),
    .xferBusy   (xferBusy),
    .xferDone   (xferDone)
  );

  pio_port_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .flags       (flags),
    .hostWData   (hostWData),
    .hostRData   (hostRData),
    .hostAck     (hostAck),
    .hostRetry   (hostRetry),
    .linkRxValid (linkRxValid),
    .linkRxData  (linkRxData),
    .linkRxReady (linkRxReady),
    .linkTxPop   (linkTxPop),
    .linkTxData  (linkTxData),
    .linkTxValid (linkTxValid)
  );

  assert_strap_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    $stable(dpaMode));

endmodule

// File: tb/test_pio_sector_port.sv
module test_pio_sector_port;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int SW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeStrap = 1'b1;
  logic dpaMode;
  logic hostRd = 0, hostWr = 0;
  logic [DW-1:0] hostWData = '0, hostRData;
  logic hostAck, hostRetry;
  logic statusRd = 0, cmdStart = 0, cmdIsWrite = 0, cmdMulti = 0;
  logic [CW-1:0] cmdCount = '0, cfgBlkData = '0;
  logic cfgBlkWe = 0;
  logic irq, xferBusy, xferDone;
  logic linkRxValid = 0;
  logic [DW-1:0] linkRxData = '0, linkTxData;
  logic linkRxReady, linkTxPop = 0, linkTxValid;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_sector_port #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .SECTOR_WORDS(SW), .CNT_W(CW))
  i_pio_sector_port (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .dpaMode(dpaMode),
    .hostRd(hostRd), .hostWr(hostWr), .hostWData(hostWData), .hostRData(hostRData),
    .hostAck(hostAck), .hostRetry(hostRetry), .statusRd(statusRd),
    .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite), .cmdMulti(cmdMulti),
    .cmdCount(cmdCount), .cfgBlkWe(cfgBlkWe), .cfgBlkData(cfgBlkData),
    .irq(irq), .xferBusy(xferBusy), .xferDone(xferDone),
    .linkRxValid(linkRxValid), .linkRxData(linkRxData), .linkRxReady(linkRxReady),
    .linkTxPop(linkTxPop), .linkTxData(linkTxData), .linkTxValid(linkTxValid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected interrupt after host beat w of sector s (bench model of R6/R7)
  function automatic bit expIrq(int s, int w, int count, int bs);
    return (w == SW - 1) && (s + 1 < count) && (((s + 1) % bs) == 0);
  endfunction

  // Each task drives at a falling edge; results are sampled at the next one
  task automatic linkPush(input logic [DW-1:0] d);
    @(negedge clk); linkRxValid = 1; linkRxData = d;
    @(negedge clk); linkRxValid = 0;
  endtask

  task automatic hostRead(output logic ack, output logic rty, output logic [DW-1:0] d);
    @(negedge clk); hostRd = 1;
    @(negedge clk); hostRd = 0;
    ack = hostAck; rty = hostRetry; d = hostRData;
  endtask

  task automatic hostWrite(input logic [DW-1:0] d, output logic ack, output logic rty);
    @(negedge clk); hostWr = 1; hostWData = d;
    @(negedge clk); hostWr = 0;
    ack = hostAck; rty = hostRetry;
  endtask

  task automatic linkPop(output logic [DW-1:0] d);
    @(negedge clk); linkTxPop = 1;
    @(negedge clk); linkTxPop = 0;
    d = linkTxData;
  endtask

  task automatic pulseStatus();
    @(negedge clk); statusRd = 1;
    @(negedge clk); statusRd = 0;
  endtask

  task automatic runXfer(input bit isWr, input int count, input bit multi, input int blk);
    int bs;
    logic ack, rty;
    logic [DW-1:0] d, got;
    bs = multi ? ((blk == 0) ? 1 : blk) : 1;
    @(negedge clk); cfgBlkWe = 1; cfgBlkData = CW'(blk);
    @(negedge clk); cfgBlkWe = 0;
    cmdStart = 1; cmdIsWrite = isWr; cmdMulti = multi; cmdCount = CW'(count);
    @(negedge clk); cmdStart = 0;
    chk(xferBusy === 1'b1, "R5 busy after start", xferBusy, 1);
    chk(irq === 1'b1, "R5 irq after start", irq, 1);
    chk(xferDone === 1'b0, "R9 done cleared by start", xferDone, 0);
    pulseStatus();
    chk(irq === 1'b0, "R8 status read clears irq", irq, 0);
    for (int s = 0; s < count; s++) begin
      for (int w = 0; w < SW; w++) begin
        d = DW'($urandom);
        if (isWr) begin
          hostWrite(d, ack, rty);
          chk(ack === 1'b1 && rty === 1'b0, "R2 write ack", {ack, rty}, 2'b10);
          // Before the link drains, check the interrupt for this beat
          chk(irq === expIrq(s, w, count, bs), multi ? "R7 block irq" : "R6 sector irq",
              irq, expIrq(s, w, count, bs));
          linkPop(got);
          chk(got === d, "R2 link data order", got, d);
        end else begin
          linkPush(d);
          hostRead(ack, rty, got);
          chk(ack === 1'b1 && got === d, "R1 read data", got, d);
          chk(irq === expIrq(s, w, count, bs), multi ? "R7 block irq" : "R6 sector irq",
              irq, expIrq(s, w, count, bs));
        end
        if (irq) pulseStatus();
      end
    end
    chk(xferBusy === 1'b0 && xferDone === 1'b1, "R9 completion", {xferBusy, xferDone}, 2'b01);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic ack, rty;
    logic [DW-1:0] got;
    logic [DW-1:0] q [$];
    void'($urandom(32'h5EC7_0A11));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(dpaMode === 1'b1, "R10 strap captured", dpaMode, 1);
    chk(irq === 0 && xferBusy === 0 && xferDone === 0, "R5 reset idle",
        {irq, xferBusy, xferDone}, 0);
    chk(hostAck === 0 && hostRetry === 0, "R1 reset no response", {hostAck, hostRetry}, 0);
    chk(linkRxReady === 1 && linkTxValid === 0, "R4 reset fifo flags",
        {linkRxReady, linkTxValid}, 2'b10);
    modeStrap = 0;
    repeat (4) @(negedge clk);
    chk(dpaMode === 1'b1, "R10 strap held after reset", dpaMode, 1);

    // R3: read of an empty receive FIFO
    hostRead(ack, rty, got);
    chk(rty === 1'b1 && ack === 1'b0, "R3 empty read retry", {ack, rty}, 2'b01);

    // R4 / R1: fill the receive FIFO, overflow attempt, drain in order
    for (int i = 0; i < DEPTH; i++) begin
      got = DW'($urandom); q.push_back(got); linkPush(got);
    end
    chk(linkRxReady === 1'b0, "R4 ready low when full", linkRxReady, 0);
    linkPush(16'hDEAD);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(ack, rty, got);
      chk(ack === 1'b1 && got === q[i], "R1 fifo order", got, q[i]);
    end
    hostRead(ack, rty, got);
    chk(rty === 1'b1, "R4 push while full ignored", rty, 1);
    q.delete();

    // R3 / R2: fill the transmit FIFO, refused write, drain in order
    for (int i = 0; i < DEPTH; i++) begin
      got = DW'($urandom); q.push_back(got); hostWrite(got, ack, rty);
      chk(ack === 1'b1, "R2 write accepted", ack, 1);
    end
    hostWrite(16'hBEEF, ack, rty);
    chk(rty === 1'b1 && ack === 1'b0, "R3 full write retry", {ack, rty}, 2'b01);
    for (int i = 0; i < DEPTH; i++) begin
      linkPop(got);
      chk(got === q[i], "R3 queue intact after retry", got, q[i]);
    end
    chk(linkTxValid === 1'b0, "R3 refused word not stored", linkTxValid, 0);
    q.delete();

    // R5: zero sector count ignored
    @(negedge clk); cmdStart = 1; cmdCount = '0;
    @(negedge clk); cmdStart = 0;
    chk(xferBusy === 1'b0 && irq === 1'b0, "R5 zero count ignored", {xferBusy, irq}, 0);

    // Directed transfers
    runXfer(1'b0, 3, 1'b0, 4);   // R6 single-sector read
    runXfer(1'b0, 5, 1'b1, 2);   // R7 blocks 2,2,1
    runXfer(1'b1, 4, 1'b1, 3);   // R7 write, blocks 3,1
    runXfer(1'b1, 1, 1'b0, 1);   // minimum count
    runXfer(1'b0, 3, 1'b1, 0);   // R7 block size 0 behaves as 1

    // Constrained random transfers
    for (int t = 0; t < 6; t++) begin
      runXfer(1'($urandom), 1 + int'($urandom % 6), 1'($urandom), 1 + int'($urandom % 4));
    end

    chk(dpaMode === 1'b1, "R10 strap still held", dpaMode, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule